// File: doc/BRIEF.md
# Directory-Carrying Block ECC Codec

This codec protects a 32-byte memory block whose spare check storage also holds a 14-bit cache-coherence directory entry. Conventional protection spends 8 check bits on every 64-bit word, which is 32 bits per block. Here the block is split into two 128-bit halves. Each half gets a 9-bit single-error-correct, double-error-detect code, which uses 18 bits. The other 14 bits hold the directory state and pointer, so the directory lives in main memory next to its data and needs no storage of its own.

The encode path is combinational. It takes 256 data bits and the directory field and returns the 32 stored bits. The decode path takes the 256 stored data bits and 32 stored check bits with an enable. One clock later it presents the corrected data, the corrected directory, a corrected-error flag, an uncorrectable flag and a valid strobe. The single register stage lets the check overlap execution, so a faulting access can be stopped before it retires. The check code of the upper half also covers the directory bits.

Top module: `ecc_dir_codec`

## Requirements
- R1: Encoding puts the directory on stored bits [31:18]. Stored bits [17:0] are all zero when the data and directory are all zero, and they are linear: the code of A XOR B equals the code of A XOR the code of B.
- R2: A read of an unaltered encoded block returns the original data and directory, with both error flags low.
- R3: A single flipped bit anywhere in the 288 stored bits is corrected, with ce=1 and ue=0. The lower half is data[127:0] plus check[8:0]. The upper half is data[255:128] plus check[17:9] plus directory bits check[31:18].
- R4: Two flipped bits in the same half raise ue=1, with ce=0 when the other half is clean.
- R5: When ue=1, the data and directory outputs equal the raw stored inputs of that read, never a partly corrected value.
- R6: One flipped bit in each half in the same read is corrected in both halves, with ce=1 and ue=0.
- R7: A single flip in one half together with a double flip in the other half raises ue=1.
- R8: The outputs of a read appear exactly one clock after the enable cycle, with out_vld=1. When no read was enabled in the previous cycle, out_vld, out_ce and out_ue are 0. Back-to-back reads give one result per cycle.
- R9: While reset (rst_n low) is asserted, out_vld, out_ce and out_ue are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data | input | 256 | Data to encode |
| enc_dir | input | 14 | Directory entry to store |
| enc_chk | output | 32 | Stored check and directory bits |
| dec_en | input | 1 | Read data presented this cycle |
| dec_data | input | 256 | Stored data being read |
| dec_chk | input | 32 | Stored check and directory bits being read |
| out_vld | output | 1 | Decode result valid |
| out_data | output | 256 | Corrected data |
| out_dir | output | 14 | Corrected directory entry |
| out_ce | output | 1 | A single error was corrected |
| out_ue | output | 1 | An uncorrectable error was found |

## Verification
The two halves are decoded side by side, so a correction in one half and a detection in the other can land in the same cycle. The bench provokes this by flipping one bit in the lower half and either one bit or two adjacent bits in the upper half of the same read. A single flip in each half must give fully corrected data and directory with only ce set. A single flip beside a double flip must set ue and return the raw input unchanged. Every single flip and every same-half double flip is swept exhaustively over the stored bits, including the directory bits.

// File: rtl/ecc_dir_codec.sv
module ecc_dir_codec #(
  parameter int HALF_W = 128,
  parameter int DIR_W  = 14
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [2*HALF_W-1:0]             enc_data,
  input  logic [DIR_W-1:0]                enc_dir,
  output logic [2*(hbits(HALF_W+DIR_W)+1)+DIR_W-1:0] enc_chk,
  input  logic                            dec_en,
  input  logic [2*HALF_W-1:0]             dec_data,
  input  logic [2*(hbits(HALF_W+DIR_W)+1)+DIR_W-1:0] dec_chk,
  output logic                            out_vld,
  output logic [2*HALF_W-1:0]             out_data,
  output logic [DIR_W-1:0]                out_dir,
  output logic                            out_ce,
  output logic                            out_ue
);

  function automatic int hbits(input int k);
    int r;
    r = 1;
    while ((1 << r) < k + r + 1) r++;
    return r;
  endfunction

  localparam int DATA_W  = 2 * HALF_W;
  localparam int EXT_W   = HALF_W + DIR_W;
  localparam int HB      = hbits(EXT_W);
  localparam int CHK_W   = HB + 1;
  localparam int STORE_W = 2 * CHK_W + DIR_W;

  function automatic logic [HB-1:0] hsyn(input logic [EXT_W-1:0] d);
    logic [HB-1:0] s;
    int p;
    s = '0;
    p = 2;
    for (int i = 0; i < EXT_W; i++) begin
      p = p + 1;
      if ((p & (p - 1)) == 0) p = p + 1;
      if (d[i]) s = s ^ HB'(p);
    end
    return s;
  endfunction

  function automatic logic [CHK_W-1:0] henc(input logic [EXT_W-1:0] d);
    logic [HB-1:0] h;
    h = hsyn(d);
    return {(^d) ^ (^h), h};
  endfunction

  assign enc_chk = {enc_dir,
                    henc({enc_dir, enc_data[DATA_W-1:HALF_W]}),
                    henc({{DIR_W{1'b0}}, enc_data[HALF_W-1:0]})};

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam int LIM = (h == 0) ? HALF_W : EXT_W;
    logic [LIM-1:0]   rx, fx;
    logic [CHK_W-1:0] rc;
    logic [HB-1:0]    syn;
    logic             ovr, c, u;

    if (h == 0) begin : g_lo
      assign rx = dec_data[HALF_W-1:0];
    end else begin : g_hi
      assign rx = {dec_chk[STORE_W-1 -: DIR_W], dec_data[DATA_W-1:HALF_W]};
    end

    assign rc  = dec_chk[h*CHK_W +: CHK_W];
    assign syn = hsyn(EXT_W'(rx)) ^ rc[HB-1:0];
    assign ovr = (^rx) ^ (^rc);

    always_comb begin
      int p;
      fx = rx;
      c  = 1'b0;
      u  = 1'b0;
      p  = 2;
      if (ovr) begin
        if (syn == '0 || (syn & (syn - 1'b1)) == '0) begin
          c = 1'b1;
        end else begin
          u = 1'b1;
          for (int i = 0; i < LIM; i++) begin
            p = p + 1;
            if ((p & (p - 1)) == 0) p = p + 1;
            if (HB'(p) == syn) begin
              fx[i] = ~rx[i];
              u = 1'b0;
              c = 1'b1;
            end
          end
        end
      end else if (syn != '0) begin
        u = 1'b1;
      end
    end
  end

  logic             any_ce, any_ue;
  logic [HALF_W-1:0] fix_lo;
  logic [EXT_W-1:0]  fix_hi;

  assign fix_lo = g_half[0].fx;
  assign fix_hi = g_half[1].fx;
  assign any_ce = g_half[0].c | g_half[1].c;
  assign any_ue = g_half[0].u | g_half[1].u;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_ce   <= 1'b0;
      out_ue   <= 1'b0;
      out_data <= '0;
      out_dir  <= '0;
    end else begin
      out_vld <= dec_en;
      out_ce  <= dec_en & any_ce;
      out_ue  <= dec_en & any_ue;
      if (dec_en) begin
        if (any_ue) begin
          out_data <= dec_data;
          out_dir  <= dec_chk[STORE_W-1 -: DIR_W];
        end else begin
          out_data <= {fix_hi[HALF_W-1:0], fix_lo};
          out_dir  <= fix_hi[EXT_W-1:HALF_W];
        end
      end
    end
  end

endmodule

// File: rtl/ecc_dir_codec_chk.sv
module ecc_dir_codec_chk #(
  parameter int DATA_W  = 256,
  parameter int DIR_W   = 14,
  parameter int STORE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dec_en,
  input logic [DATA_W-1:0]  dec_data,
  input logic [STORE_W-1:0] dec_chk,
  input logic               out_vld,
  input logic [DATA_W-1:0]  out_data,
  input logic [DIR_W-1:0]   out_dir,
  input logic               out_ce,
  input logic               out_ue
);

  a_r8_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> out_vld);

  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> (!out_vld && !out_ce && !out_ue));

  a_r2_clean_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> ((out_ce || out_ue) ||
                (out_data == $past(dec_data) &&
                 out_dir == $past(dec_chk[STORE_W-1 -: DIR_W]))));

  a_r5_raw_on_ue: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> (!out_ue ||
                (out_data == $past(dec_data) &&
                 out_dir == $past(dec_chk[STORE_W-1 -: DIR_W]))));

  a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ce || out_ue) |-> out_vld);

endmodule

bind ecc_dir_codec ecc_dir_codec_chk #(
  .DATA_W(DATA_W), .DIR_W(DIR_W), .STORE_W(STORE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .dec_data(dec_data),
  .dec_chk(dec_chk), .out_vld(out_vld), .out_data(out_data),
  .out_dir(out_dir), .out_ce(out_ce), .out_ue(out_ue)
);

// File: tb/ecc_dir_codec_bench.sv
module ecc_dir_codec_bench;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] enc_data = '0;
  logic [13:0]  enc_dir = '0;
  logic [31:0]  enc_chk;
  logic         dec_en = 1'b0;
  logic [255:0] dec_data = '0;
  logic [31:0]  dec_chk = '0;
  logic         out_vld;
  logic [255:0] out_data;
  logic [13:0]  out_dir;
  logic         out_ce, out_ue;

  int total = 0;
  int bad = 0;

  ecc_dir_codec u_ecc_dir_codec (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_dir(enc_dir),
    .enc_chk(enc_chk), .dec_en(dec_en), .dec_data(dec_data),
    .dec_chk(dec_chk), .out_vld(out_vld), .out_data(out_data),
    .out_dir(out_dir), .out_ce(out_ce), .out_ue(out_ue)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL R8 watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int widx(input int h, input int k);
    if (h == 0) return (k < 128) ? k : 256 + k - 128;
    return (k < 128) ? 128 + k : 265 + k - 128;
  endfunction

  task automatic check(input string req, input logic [300:0] act,
                       input logic [300:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic enc(input logic [255:0] d, input logic [13:0] dr,
                     output logic [31:0] c);
    enc_data = d;
    enc_dir = dr;
    #1;
    c = enc_chk;
  endtask

  task automatic rd(input string req, input logic [287:0] w,
                    input logic [255:0] ed, input logic [13:0] edir,
                    input logic ece, input logic chk_ce, input logic eue);
    @(negedge clk);
    dec_en = 1'b1;
    dec_data = w[255:0];
    dec_chk = w[287:256];
    @(negedge clk);
    dec_en = 1'b0;
    check(req, {out_vld, out_ue, out_dir, out_data}, {1'b1, eue, edir, ed});
    if (chk_ce) check(req, out_ce, ece);
  endtask

  initial begin
    logic [255:0] pd [3];
    logic [13:0]  pr [3];
    logic [31:0]  c, ca, cb;
    logic [287:0] w, w2;

    pd[0] = {8{32'hC3A5_5A3C}} ^ {4{64'h0123_4567_89AB_CDEF}};
    pr[0] = 14'h1A5B;
    pd[1] = '1;
    pr[1] = 14'h3FFF;
    pd[2] = {16{16'h8001}};
    pr[2] = 14'h0241;

    repeat (2) @(negedge clk);
    check("R9 reset flags", {out_vld, out_ce, out_ue}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", {out_vld, out_ce, out_ue}, 3'b000);

    enc('0, '0, c);
    check("R1 zero code", c, 32'h0);
    for (int p = 0; p < 3; p++) begin
      enc(pd[p], pr[p], c);
      check("R1 directory copy", c[31:18], pr[p]);
      enc(pd[(p+1)%3], '0, ca);
      enc(pd[p] ^ pd[(p+1)%3], pr[p], cb);
      check("R1 linear", cb[17:0], c[17:0] ^ ca[17:0]);
    end

    for (int p = 0; p < 3; p++) begin
      enc(pd[p], pr[p], c);
      w = {c, pd[p]};
      rd("R2 clean read", w, pd[p], pr[p], 1'b0, 1'b1, 1'b0);
      for (int b = 0; b < 288; b++) begin
        w2 = w ^ (288'b1 << b);
        rd("R3 single flip", w2, pd[p], pr[p], 1'b1, 1'b1, 1'b0);
      end
    end

    enc(pd[0], pr[0], c);
    w = {c, pd[0]};
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < ((h == 0) ? 137 : 151); i++) begin
        for (int j = i + 1; j < ((h == 0) ? 137 : 151); j++) begin
          w2 = w ^ (288'b1 << widx(h, i)) ^ (288'b1 << widx(h, j));
          rd("R4 R5 same-half double", w2, w2[255:0], w2[287:274],
             1'b0, 1'b1, 1'b1);
        end
      end
    end

    for (int p = 0; p < 3; p++) begin
      enc(pd[p], pr[p], c);
      w = {c, pd[p]};
      for (int i = 0; i < 137; i += 4) begin
        w2 = w ^ (288'b1 << widx(0, i)) ^ (288'b1 << widx(1, (i * 3 + p) % 151));
        rd("R6 one flip per half", w2, pd[p], pr[p], 1'b1, 1'b1, 1'b0);
        w2 = w ^ (288'b1 << widx(0, i)) ^ (288'b1 << widx(1, (i * 5) % 150))
               ^ (288'b1 << widx(1, (i * 5) % 150 + 1));
        rd("R7 single plus double", w2, w2[255:0], w2[287:274],
           1'b0, 1'b0, 1'b1);
        w2 = w ^ (288'b1 << widx(1, i)) ^ (288'b1 << widx(0, i % 136))
               ^ (288'b1 << widx(0, i % 136 + 1));
        rd("R7 double low single high", w2, w2[255:0], w2[287:274],
           1'b0, 1'b0, 1'b1);
      end
    end

    enc(pd[1], pr[1], ca);
    enc(pd[2], pr[2], cb);
    @(negedge clk);
    dec_en = 1'b1;
    dec_data = pd[1];
    dec_chk = ca;
    @(negedge clk);
    check("R8 first of pair", {out_vld, out_ce, out_ue, out_dir, out_data},
          {3'b100, pr[1], pd[1]});
    dec_data = pd[2] ^ 256'h4;
    dec_chk = cb;
    @(negedge clk);
    dec_en = 1'b0;
    check("R8 second of pair", {out_vld, out_ce, out_ue, out_dir, out_data},
          {3'b110, pr[2], pd[2]});
    dec_data = '1;
    dec_chk = '0;
    @(negedge clk);
    check("R8 no enable no result", {out_vld, out_ce, out_ue}, 3'b000);
    @(negedge clk);
    check("R8 stays idle", {out_vld, out_ce, out_ue}, 3'b000);

    dec_en = 1'b1;
    dec_data = pd[0];
    dec_chk = c;
    rst_n = 1'b0;
    #1;
    check("R9 reset clears mid-read", {out_vld, out_ce, out_ue}, 3'b000);
    @(negedge clk);
    check("R9 held in reset", {out_vld, out_ce, out_ue}, 3'b000);
    dec_en = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule